// File: doc/BRIEF.md
# Configuration DMA command queue controller

This block is the register front end of a DMA engine that streams configuration data to a downstream port. Software first writes a key to release a write lock. It then stages a transfer in three registers: source address, destination address and source length in 32-bit words. Writing the destination-length register commits the staged transfer into a four-entry command queue. The engine takes commands from the queue in order. For each one it counts words, emitting one word per cycle through a registered ready/valid output. Each emitted word carries the word address it models.

A command whose source address has bit 0 set is the final one of a sequence. For that command, a separate combined-done status bit is raised only once the output register has been drained by the consumer. The engine starts no further command until that happens. A destination address of all ones means the words go to the port. Any other destination is a write-back transfer: its words are consumed internally, one per cycle, and never appear on the port.

Interrupt status bits are cleared by writing a one to them. The mask register works inverted: a 1 blocks the matching source. The `irq` output is high when any status bit is set whose mask bit is 0.

Top module: `cfg_dma_cmdq`

## Requirements
- R1: Until 0x757BDF0D has been written to offset 0x34, every register write is ignored and offset 0x04 reads 1. After that key, offset 0x04 reads 0, and writes to offset 0x00 and offset 0x80 are stored and read back.
- R2: After reset, these values hold: offset 0x14 reads 0x40000000, offset 0x10 reads 0xFFFFFFFF, offset 0x0C reads 0, and `irq` is low.
- R3: A write to offset 0x24 enqueues the values then held at offsets 0x18, 0x1C and 0x20. The queue holds 4 commands. Bit 31 of offset 0x14 is 1 while 4 are held, and bit 30 is 1 while none is held.
- R4: A write to offset 0x24 while the queue is full discards the command and sets bit 11 of offset 0x0C. Bit 11 belongs to the error group 0x00F0C860.
- R5: Commands run in push order. For a command with destination 0xFFFFFFFF and length N, exactly N words leave on `out_data`. Their values are the source address with bits 1:0 cleared, then +4 for each further word. While `out_ready` is low, `out_valid` and `out_data` hold.
- R6: Bit 13 of offset 0x0C is set when the engine has issued the last word of a command. For length 0, it is set with no word issued.
- R7: For a command whose source bit 0 is 1, bit 12 of offset 0x0C is set only after its last word has been accepted and `out_valid` is low. No later command starts before then.
- R8: A command whose destination is not 0xFFFFFFFF puts no word on the port, yet still sets bit 13.
- R9: Writing offset 0x0C clears each status bit written as 1 and leaves the bits written as 0 unchanged.
- R10: `irq` is the OR of the status bits whose mask bit (offset 0x10) is 0. With the mask all ones, `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |
| out_ready | input | 1 | Consumer accepts the word |
| irq | output | 1 | Interrupt request |

## Verification
The engine is driven from a table of single commands. The table covers a plain forwarded transfer, a final-flagged transfer with odd source bits, a zero-length command, a write-back destination, and a transfer under an irregular ready pattern. Together these separate word count and address stepping, the bit-0 flag, the empty case, the port-bypass path and handshake holding. Directed tests then hold `out_ready` low to show that the combined-done bit waits for the drain and that queued work waits behind a final command. They also fill the queue past its depth to show the discard, and exercise the lock, write-one-to-clear and mask inversion.

// File: rtl/cfg_dma_cmdq.sv
module cfg_dma_cmdq #(
  parameter int          DEPTH = 4,
  parameter int          AW    = 8,
  parameter logic [31:0] KEY   = 32'h757B_DF0D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          out_valid,
  output logic [31:0]   out_data,
  input  logic          out_ready,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [31:0] IMPL = 32'hF8F7_F87F;
  localparam logic [AW-1:0] A_CTRL = AW'('h00), A_LOCK = AW'('h04), A_ISTS = AW'('h0C),
                            A_MASK = AW'('h10), A_STAT = AW'('h14), A_SRC  = AW'('h18),
                            A_DST  = AW'('h1C), A_SLEN = AW'('h20), A_DLEN = AW'('h24),
                            A_KEY  = AW'('h34), A_MISC = AW'('h80);

  logic        unlocked;
  logic [31:0] ctrl_q, misc_q, mask_q, sts_q, src_q, dst_q, len_q;
  logic [31:0] q_src [DEPTH];
  logic [31:0] q_dst [DEPTH];
  logic [31:0] q_len [DEPTH];
  logic [PW:0] wp, rp, used;
  logic        full, empty, wr_ok, push_req, push, pop;
  logic        busy, fwd, last, pend_last;
  logic [31:0] cnt, cur;
  logic        step, fin, drained;
  logic [31:0] set_v, clr_v;

  assign wr_ok    = reg_wr && unlocked;
  assign used     = wp - rp;
  assign full     = used == (PW+1)'(DEPTH);
  assign empty    = wp == rp;
  assign push_req = wr_ok && reg_addr == A_DLEN;
  assign push     = push_req && !full;
  assign pop      = !busy && !pend_last && !empty;
  assign step     = busy && cnt != 0 && (!fwd || !out_valid || out_ready);
  assign fin      = busy && cnt == 0;
  assign drained  = pend_last && !out_valid;
  assign set_v    = {18'b0, fin, drained, push_req && full, 11'b0};
  assign clr_v    = (wr_ok && reg_addr == A_ISTS) ? (reg_wdata & IMPL) : 32'b0;
  assign irq      = |(sts_q & ~mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      ctrl_q   <= '0;
      misc_q   <= '0;
      mask_q   <= '1;
      sts_q    <= '0;
      src_q    <= '0;
      dst_q    <= '1;
      len_q    <= '0;
    end else begin
      if (reg_wr && reg_addr == A_KEY && reg_wdata == KEY) unlocked <= 1'b1;
      if (wr_ok) begin
        case (reg_addr)
          A_CTRL: ctrl_q <= reg_wdata;
          A_MISC: misc_q <= reg_wdata;
          A_MASK: mask_q <= reg_wdata;
          A_SRC:  src_q  <= reg_wdata;
          A_DST:  dst_q  <= reg_wdata;
          A_SLEN: len_q  <= reg_wdata;
          default: ;
        endcase
      end
      sts_q <= (sts_q & ~clr_v) | set_v;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_src[wp[PW-1:0]] <= src_q;
      q_dst[wp[PW-1:0]] <= dst_q;
      q_len[wp[PW-1:0]] <= len_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      busy <= 1'b0;
      fwd <= 1'b0;
      last <= 1'b0;
      pend_last <= 1'b0;
      cnt <= '0;
      cur <= '0;
      out_valid <= 1'b0;
      out_data <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop) begin
        rp   <= rp + 1'b1;
        busy <= 1'b1;
        cnt  <= q_len[rp[PW-1:0]];
        cur  <= {q_src[rp[PW-1:0]][31:2], 2'b00};
        last <= q_src[rp[PW-1:0]][0];
        fwd  <= q_dst[rp[PW-1:0]] == '1;
      end
      if (fin) begin
        busy <= 1'b0;
        if (last) pend_last <= 1'b1;
      end
      if (drained) pend_last <= 1'b0;
      if (step) begin
        cnt <= cnt - 1'b1;
        cur <= cur + 32'd4;
      end
      if (step && fwd) begin
        out_valid <= 1'b1;
        out_data  <= cur;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_LOCK:  reg_rdata = {31'b0, !unlocked};
      A_ISTS:  reg_rdata = sts_q;
      A_MASK:  reg_rdata = mask_q;
      A_STAT:  reg_rdata = {full, empty, 30'b0};
      A_SRC:   reg_rdata = src_q;
      A_DST:   reg_rdata = dst_q;
      A_SLEN:  reg_rdata = len_q;
      A_MISC:  reg_rdata = misc_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

module cfg_dma_cmdq_chk #(
  parameter int DEPTH = 4,
  parameter int PW    = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        unlocked,
  input logic        push_req,
  input logic        full,
  input logic        empty,
  input logic [PW:0] used,
  input logic [31:0] mask_q,
  input logic [31:0] sts_q,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        irq
);
  p_locked_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && reg_wr) |=> $stable(mask_q));
  p_full_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  p_depth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    used <= (PW+1)'(DEPTH));
  p_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full) |=> sts_q[11]);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[12]) |-> !out_valid);
  p_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq);
endmodule

bind cfg_dma_cmdq cfg_dma_cmdq_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .unlocked(unlocked),
  .push_req(push_req), .full(full), .empty(empty), .used(used),
  .mask_q(mask_q), .sts_q(sts_q), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .irq(irq)
);

// File: tb/test_cfg_dma_cmdq.sv
`timescale 1ns/100ps
module test_cfg_dma_cmdq;
  logic clk = 0, rst_n = 0, reg_wr = 0, out_ready = 0, out_valid, irq;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, out_data;
  int checks = 0, errors = 0, rdy_mode = 0, cyc = 0, rx_n = 0, base = 0;
  logic [31:0] rx [256];
  logic [31:0] r;

  localparam logic [31:0] ONES = 32'hFFFF_FFFF;
  localparam logic [31:0] V_SRC  [0:4] = '{32'h1000, 32'h2003, 32'h3000, 32'h4000, 32'h5000};
  localparam logic [31:0] V_LEN  [0:4] = '{32'd3,    32'd2,    32'd0,    32'd5,    32'd4};
  localparam logic [31:0] V_DST  [0:4] = '{ONES,     ONES,     ONES,     32'h8000, ONES};
  localparam int          V_MODE [0:4] = '{0, 1, 0, 0, 1};

  always #2.5 clk = ~clk;

  cfg_dma_cmdq i_cfg_dma_cmdq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .irq(irq));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    out_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (cyc % 3 != 0) : 1'b0;
  end

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) begin
      rx[rx_n % 256] = out_data;
      rx_n = rx_n + 1;
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] s, input logic [31:0] dd, input logic [31:0] n);
    wr(8'h18, s); wr(8'h1C, dd); wr(8'h20, n); wr(8'h24, 32'h0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    rd(8'h14, r); chk("R2 status", r, 32'h4000_0000);
    rd(8'h10, r); chk("R2 mask", r, ONES);
    rd(8'h0C, r); chk("R2 int status", r, 0);
    chk("R2 irq", {31'b0, irq}, 0);
    rd(8'h04, r); chk("R1 locked", r, 1);

    wr(8'h10, 32'h0); rd(8'h10, r); chk("R1 write ignored", r, ONES);
    wr(8'h34, 32'h1234_5678); rd(8'h04, r); chk("R1 wrong key", r, 1);
    wr(8'h34, 32'h757B_DF0D); rd(8'h04, r); chk("R1 unlocked", r, 0);
    wr(8'h00, 32'h0C00_0000); rd(8'h00, r); chk("R1 control", r, 32'h0C00_0000);
    wr(8'h80, 32'h0000_0010); rd(8'h80, r); chk("R1 misc", r, 32'h10);
    wr(8'h10, ~(32'h3000 | 32'h00F0_C860)); rd(8'h10, r);
    chk("R10 mask store", r, ~(32'h3000 | 32'h00F0_C860));

    for (int i = 0; i < 5; i++) begin
      int exp_n;
      wr(8'h0C, ONES);
      rdy_mode = V_MODE[i];
      base = rx_n;
      push(V_SRC[i], V_DST[i], V_LEN[i]);
      repeat (40) @(negedge clk);
      exp_n = (V_DST[i] == ONES) ? int'(V_LEN[i]) : 0;
      rd(8'h0C, r);
      chk("R6 done bit", {31'b0, r[13]}, 1);
      chk("R7 final bit", {31'b0, r[12]}, {31'b0, V_SRC[i][0]});
      chk(V_DST[i] == ONES ? "R5 word count" : "R8 no port words", rx_n - base, exp_n);
      for (int j = 0; j < exp_n; j++)
        chk("R5 word value", rx[(base + j) % 256], {V_SRC[i][31:2], 2'b00} + 32'(4 * j));
      chk("R10 irq on", {31'b0, irq}, 1);
    end

    wr(8'h0C, ONES);
    rdy_mode = 2;
    base = rx_n;
    push(32'h6001, ONES, 32'd1);
    repeat (10) @(negedge clk);
    rd(8'h0C, r); chk("R7 waits for drain", {30'b0, r[13:12]}, 2);
    chk("R5 held valid", {31'b0, out_valid}, 1);
    chk("R5 held data", out_data, 32'h6000);
    push(32'h7000, ONES, 32'd1);
    repeat (10) @(negedge clk);
    chk("R7 next blocked", out_data, 32'h6000);
    rd(8'h14, r); chk("R7 next still queued", r, 32'h0);
    rdy_mode = 0;
    repeat (20) @(negedge clk);
    rd(8'h0C, r); chk("R7 final after drain", {31'b0, r[12]}, 1);
    chk("R7 words after drain", rx_n - base, 2);
    chk("R5 order first", rx[base % 256], 32'h6000);
    chk("R5 order second", rx[(base + 1) % 256], 32'h7000);

    wr(8'h0C, ONES);
    rdy_mode = 2;
    base = rx_n;
    for (int k = 0; k < 5; k++) push(32'hA000 + 32'(k * 'h100), ONES, 32'd2);
    rd(8'h14, r); chk("R3 full", r, 32'h8000_0000);
    rd(8'h0C, r); chk("R4 no error yet", {31'b0, r[11]}, 0);
    push(32'hA500, ONES, 32'd2);
    rd(8'h0C, r); chk("R4 overflow flag", {31'b0, r[11]}, 1);
    rdy_mode = 0;
    repeat (60) @(negedge clk);
    chk("R4 discarded count", rx_n - base, 10);
    for (int k = 0; k < 5; k++)
      for (int j = 0; j < 2; j++)
        chk("R3 queued words", rx[(base + 2 * k + j) % 256], 32'hA000 + 32'(k * 'h100 + 4 * j));
    rd(8'h14, r); chk("R3 empty again", r, 32'h4000_0000);

    wr(8'h0C, 32'h2000); rd(8'h0C, r);
    chk("R9 clear one bit", r & 32'h2800, 32'h0800);
    wr(8'h0C, 32'h0); rd(8'h0C, r);
    chk("R9 zero write keeps", r & 32'h0800, 32'h0800);
    chk("R10 irq unmasked error", {31'b0, irq}, 1);
    wr(8'h10, ONES);
    chk("R10 irq masked", {31'b0, irq}, 0);
    wr(8'h0C, 32'h0800); rd(8'h0C, r);
    chk("R9 cleared", r, 0);

    finish_run();
  end
endmodule